// File: doc/BRIEF.md
# Precision-Configurable Integer MAC Lane Array

This block is a bank of integer multiply-accumulate lanes that all run in lock step. In its normal mode every lane takes one byte from each of two operand vectors and multiplies them. It adds the product into its own 29-bit accumulator whenever the input strobe is high. A mode input chooses whether bytes are read as two's-complement or as plain binary. A second mode input fuses each group of four neighbouring lanes into one 16x16 multiply-accumulate. The four 8x8 multipliers of the group then compute the four partial products of the wide operands, and the group keeps a single 58-bit accumulator.

Each accumulator is read out through a rectifier and a quantizer. The rectifier clamps negative values to zero in signed mode. The quantizer applies an arithmetic right shift of 0 to 31 bits and then saturates the result into one output byte per lane. The whole readout sits in the same cycle as the output register, so the rectifier and quantizer add no extra cycles. A synchronous clear input empties all accumulators so that a new dot product can start.

Top module: `mac_lane_array`

## Requirements
- R1: While reset is high, and on the first output cycle after it, every output byte is zero and every accumulator is empty.
- R2: In narrow unsigned mode, lane k accumulates the product of byte k of `a_vec` and byte k of `b_vec` (byte k is bits 8k+7..8k), with both bytes read as plain binary, on every cycle where `in_valid` is high.
- R3: In narrow signed mode, both bytes of each lane are read as two's complement and the signed product is accumulated.
- R4: On a cycle where `in_valid` is low, the operand values have no effect and every accumulator keeps its value.
- R5: `clr` empties every accumulator on the next clock edge and takes priority over `in_valid` in the same cycle.
- R6: In wide mode (`wide_mode`=1), group g forms A = {byte 4g+1, byte 4g} of `a_vec` and B = {byte 4g+1, byte 4g} of `b_vec`, and accumulates A·B into a 58-bit accumulator. Bytes 4g+2 and 4g+3 are ignored. The result appears on output byte 4g, and output bytes 4g+1 to 4g+3 are zero.
- R7: In wide signed mode, A and B are read as 16-bit two's complement values.
- R8: With `relu_en` high in signed mode, a negative accumulator reads out as zero and a positive value passes unchanged. This holds in both narrow and wide mode.
- R9: Readout shifts the accumulator right by `shift_amt` (arithmetically in signed mode). It then saturates to -128..127 in signed mode (output byte in two's complement) or to 0..255 in unsigned mode.
- R10: A narrow accumulator holds 8192 full-scale unsigned products (255·255) without overflow. Past 2^29 it wraps modulo 2^29 and does not saturate.
- R11: The output vector is registered. An operand pair sampled with `in_valid` at clock edge n shows on `q_vec` after edge n+1, and not after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous accumulator clear |
| in_valid | input | 1 | Accumulate the current operands this cycle |
| signed_mode | input | 1 | 1: two's-complement operands and readout, 0: unsigned |
| wide_mode | input | 1 | 1: fuse groups of four lanes into 16x16 MACs |
| relu_en | input | 1 | Clamp negative accumulators to zero on readout |
| shift_amt | input | 5 | Right-shift amount applied before saturation |
| a_vec | input | LANES*8 | First operand, one byte per lane |
| b_vec | input | LANES*8 | Second operand, one byte per lane |
| q_vec | output | LANES*8 | Quantized result, one byte per lane |

## Verification
The assertions assume that `wide_mode` and `signed_mode` stay constant between one clear and the next. An accumulator filled in one layout has no defined meaning in the other layout. The stimulus keeps to this: every vector starts with a clear cycle in which the modes are set, and the modes are not changed until the next clear. Only `shift_amt` and `relu_en` are changed while values are held, because they act on the readout alone.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int LANE_W  = 8;
  localparam int GROUP   = 4;
  localparam int GRP_W   = LANE_W * GROUP;
  localparam int SHIFT_W = 5;
  localparam int PROD_W  = 2 * (LANE_W + 1);
endpackage

// File: rtl/mac_readout.sv
module mac_readout
  import mac_pkg::*;
#(
  parameter int EW = 59
) (
  input  logic signed [EW-1:0]      val_i,
  input  logic                      signed_mode,
  input  logic                      relu_en,
  input  logic        [SHIFT_W-1:0] shift_i,
  output logic        [LANE_W-1:0]  q_o
);
  localparam logic signed [EW-1:0] S_MAX = EW'(2 ** (LANE_W - 1) - 1);
  localparam logic signed [EW-1:0] S_MIN = -EW'(2 ** (LANE_W - 1));
  localparam logic signed [EW-1:0] U_MAX = EW'(2 ** LANE_W - 1);

  logic signed [EW-1:0] rect;
  logic signed [EW-1:0] shifted;

  always_comb begin
    rect    = (relu_en && signed_mode && (val_i < 0)) ? '0 : val_i;
    shifted = rect >>> shift_i;
    if (signed_mode) begin
      if (shifted > S_MAX)      q_o = S_MAX[LANE_W-1:0];
      else if (shifted < S_MIN) q_o = S_MIN[LANE_W-1:0];
      else                      q_o = shifted[LANE_W-1:0];
    end else begin
      if (shifted > U_MAX)      q_o = U_MAX[LANE_W-1:0];
      else                      q_o = shifted[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/mac_lane_group.sv
module mac_lane_group
  import mac_pkg::*;
#(
  parameter int ACC_W = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_valid,
  input  logic               signed_mode,
  input  logic               wide_mode,
  input  logic               relu_en,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [GRP_W-1:0]   a_i,
  input  logic [GRP_W-1:0]   b_i,
  output logic [GRP_W-1:0]   q_o
);
  localparam int WW = 2 * ACC_W;
  localparam int EW = WW + 1;

  logic        [ACC_W-1:0]  acc_q  [GROUP];
  logic signed [PROD_W-1:0] prod   [GROUP];
  logic signed [WW-1:0]     term   [GROUP];
  logic        [LANE_W-1:0] lane_q [GROUP];
  logic signed [WW-1:0]     wsum;
  logic signed [EW-1:0]     wval;
  logic        [GRP_W-1:0]  q_q;

  // Lane k: narrow uses its own bytes; wide takes the partial product
  // (k[0] ? A high : A low) x (k[1] ? B high : B low).
  for (genvar k = 0; k < GROUP; k++) begin : g_lane
    localparam int SH = LANE_W * ((k % 2) + (k / 2));
    logic [LANE_W-1:0] op_a, op_b;
    logic              sx_a, sx_b;
    logic signed [EW-1:0] nval, rval;

    always_comb begin
      if (wide_mode) begin
        op_a = a_i[((k % 2) * LANE_W) +: LANE_W];
        op_b = b_i[((k / 2) * LANE_W) +: LANE_W];
        sx_a = signed_mode && ((k % 2) == 1);
        sx_b = signed_mode && ((k / 2) == 1);
      end else begin
        op_a = a_i[k*LANE_W +: LANE_W];
        op_b = b_i[k*LANE_W +: LANE_W];
        sx_a = signed_mode;
        sx_b = signed_mode;
      end
    end

    assign prod[k] = $signed({sx_a & op_a[LANE_W-1], op_a}) *
                     $signed({sx_b & op_b[LANE_W-1], op_b});
    assign term[k] = WW'(prod[k]) <<< SH;

    assign nval = $signed({{(EW-ACC_W){signed_mode & acc_q[k][ACC_W-1]}}, acc_q[k]});
    if (k == 0) begin : g_first
      assign rval = wide_mode ? wval : nval;
    end else begin : g_rest
      assign rval = nval;
    end

    mac_readout #(.EW(EW)) u_readout (
      .val_i       (rval),
      .signed_mode (signed_mode),
      .relu_en     (relu_en),
      .shift_i     (shift_i),
      .q_o         (lane_q[k])
    );
  end

  always_comb begin
    wsum = '0;
    for (int k = 0; k < GROUP; k++) wsum = wsum + term[k];
  end

  assign wval = $signed({signed_mode & acc_q[1][ACC_W-1], acc_q[1], acc_q[0]});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < GROUP; k++) acc_q[k] <= '0;
    end else if (in_valid) begin
      if (wide_mode) begin
        {acc_q[1], acc_q[0]} <= {acc_q[1], acc_q[0]} + wsum;
        for (int k = 2; k < GROUP; k++) acc_q[k] <= '0;
      end else begin
        for (int k = 0; k < GROUP; k++) acc_q[k] <= acc_q[k] + ACC_W'(prod[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q <= '0;
    end else begin
      for (int k = 0; k < GROUP; k++)
        q_q[k*LANE_W +: LANE_W] <= (wide_mode && k != 0) ? '0 : lane_q[k];
    end
  end

  assign q_o = q_q;

  // R1
  reset_clears_out_chk: assert property (@(posedge clk)
    rst |=> (q_q == '0));

  // R4
  idle_holds_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> ($stable(acc_q[0]) && $stable(acc_q[1]) &&
                             $stable(acc_q[2]) && $stable(acc_q[3])));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 (q_q == '0));

  // R6
  wide_side_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wide_mode |=> (q_q[GRP_W-1:LANE_W] == '0));

  // R8
  relu_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    (relu_en && signed_mode) |=> (q_q[7] == 1'b0 && q_q[15] == 1'b0 &&
                                  q_q[23] == 1'b0 && q_q[31] == 1'b0));
endmodule

// File: rtl/mac_lane_array.sv
module mac_lane_array
  import mac_pkg::*;
#(
  parameter int LANES = 64,
  parameter int ACC_W = 29
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic                      signed_mode,
  input  logic                      wide_mode,
  input  logic                      relu_en,
  input  logic [SHIFT_W-1:0]        shift_amt,
  input  logic [LANES*LANE_W-1:0]   a_vec,
  input  logic [LANES*LANE_W-1:0]   b_vec,
  output logic [LANES*LANE_W-1:0]   q_vec
);
  localparam int NGROUPS = LANES / GROUP;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    mac_lane_group #(.ACC_W(ACC_W)) u_group (
      .clk         (clk),
      .rst         (rst),
      .clr         (clr),
      .in_valid    (in_valid),
      .signed_mode (signed_mode),
      .wide_mode   (wide_mode),
      .relu_en     (relu_en),
      .shift_i     (shift_amt),
      .a_i         (a_vec[g*GRP_W +: GRP_W]),
      .b_i         (b_vec[g*GRP_W +: GRP_W]),
      .q_o         (q_vec[g*GRP_W +: GRP_W])
    );
  end
endmodule

// File: tb/tb_mac_lane_array.sv
module tb_mac_lane_array;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int REP = LANES / 2;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [3:0]  req;
    logic        sm;
    logic        wm;
    logic        relu;
    logic [4:0]  sh;
    logic [15:0] a16;
    logic [15:0] b16;
    logic [7:0]  n;
    logic [7:0]  e0;
    logic [7:0]  e1;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{4'd2, 1'b0, 1'b0, 1'b0, 5'd0,  16'h0302, 16'h0504, 8'd3, 8'h18, 8'h2D}, // R2
    '{4'd3, 1'b1, 1'b0, 1'b0, 5'd0,  16'h07FE, 16'hFD05, 8'd2, 8'hEC, 8'hD6}, // R3
    '{4'd8, 1'b1, 1'b0, 1'b1, 5'd0,  16'h03FE, 16'h0405, 8'd2, 8'h00, 8'h18}, // R8
    '{4'd9, 1'b1, 1'b0, 1'b0, 5'd0,  16'h807F, 16'h7F7F, 8'd1, 8'h7F, 8'h80}, // R9
    '{4'd9, 1'b1, 1'b0, 1'b0, 5'd7,  16'h807F, 16'h7F7F, 8'd1, 8'h7E, 8'h81}, // R9
    '{4'd9, 1'b0, 1'b0, 1'b0, 5'd0,  16'h01FF, 16'h10FF, 8'd1, 8'hFF, 8'h10}, // R9
    '{4'd9, 1'b0, 1'b0, 1'b0, 5'd8,  16'h01FF, 16'h10FF, 8'd1, 8'hFE, 8'h00}, // R9
    '{4'd6, 1'b0, 1'b1, 1'b0, 5'd2,  16'h0102, 16'h0003, 8'd1, 8'hC1, 8'h00}, // R6
    '{4'd6, 1'b0, 1'b1, 1'b0, 5'd24, 16'h1234, 16'h5678, 8'd8, 8'h31, 8'h00}, // R6
    '{4'd7, 1'b1, 1'b1, 1'b0, 5'd4,  16'hFF00, 16'h0003, 8'd2, 8'hA0, 8'h00}, // R7
    '{4'd7, 1'b1, 1'b1, 1'b0, 5'd24, 16'h8000, 16'h8000, 8'd1, 8'h40, 8'h00}, // R7
    '{4'd8, 1'b1, 1'b1, 1'b1, 5'd4,  16'hFF00, 16'h0003, 8'd2, 8'h00, 8'h00}  // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic signed_mode = 1'b0;
  logic wide_mode = 1'b0;
  logic relu_en = 1'b0;
  logic [4:0] shift_amt = '0;
  logic [LANES*8-1:0] a_vec = '0;
  logic [LANES*8-1:0] b_vec = '0;
  logic [LANES*8-1:0] q_vec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  mac_lane_array #(.LANES(LANES)) dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .signed_mode(signed_mode), .wide_mode(wide_mode), .relu_en(relu_en),
    .shift_amt(shift_amt), .a_vec(a_vec), .b_vec(b_vec), .q_vec(q_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_ops(input logic [15:0] a16, input logic [15:0] b16);
    a_vec = {REP{a16}};
    b_vec = {REP{b16}};
  endtask

  task automatic check_all(input int req, input logic wide,
                           input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] got, exp;
    bit bad;
    bad = 1'b0;
    checks = checks + 1;
    for (int l = 0; l < LANES; l++) begin
      got = q_vec[l*8 +: 8];
      if (wide) exp = (l % 4 == 0) ? e0 : 8'h00;
      else      exp = (l % 2 == 0) ? e0 : e1;
      if (got !== exp && !bad) begin
        bad = 1'b1;
        errors = errors + 1;
        $display("FAIL R%0d lane %0d: actual=%h expected=%h", req, l, got, exp);
      end
    end
  endtask

  task automatic start_clear(input logic sm, input logic wm, input logic rl,
                             input logic [4:0] sh);
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b0;
    signed_mode = sm; wide_mode = wm; relu_en = rl; shift_amt = sh;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all(1, 1'b0, 8'h00, 8'h00); // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check_all(1, 1'b0, 8'h00, 8'h00); // R1 after release

    // Vector table walk: R2 R3 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      start_clear(VEC[v].sm, VEC[v].wm, VEC[v].relu, VEC[v].sh);
      set_ops(VEC[v].a16, VEC[v].b16);
      in_valid = 1'b1;
      repeat (int'(VEC[v].n)) @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_all(int'(VEC[v].req), VEC[v].wm, VEC[v].e0, VEC[v].e1);
    end

    // R4: operands with in_valid low change nothing
    start_clear(1'b0, 1'b0, 1'b0, 5'd0);
    set_ops(16'h0302, 16'h0504);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    set_ops(16'hFFFF, 16'hFFFF);
    repeat (5) @(negedge clk);
    check_all(4, 1'b0, 8'h08, 8'h0F);

    // R5: clear wins over a simultaneous valid
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_all(5, 1'b0, 8'h00, 8'h00);

    // R11: one-cycle pulse appears after the second edge, not the first
    set_ops(16'h0302, 16'h0504);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_all(11, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    check_all(11, 1'b0, 8'h08, 8'h0F);

    // R1: reset in the middle of accumulation
    set_ops(16'h0101, 16'h0101);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all(1, 1'b0, 8'h00, 8'h00);

    // R10: 8192 full-scale products fit; one more batch wraps mod 2^29
    start_clear(1'b0, 1'b0, 1'b0, 5'd21);
    set_ops(16'hFFFF, 16'hFFFF);
    in_valid = 1'b1;
    repeat (8192) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_all(10, 1'b0, 8'hFE, 8'hFE);
    in_valid = 1'b1;
    repeat (65) @(negedge clk);
    in_valid = 1'b0;
    shift_amt = 5'd8;
    repeat (2) @(negedge clk);
    check_all(10, 1'b0, 8'h9E, 8'h9E);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule